// File: doc/BRIEF.md
# Systolic 4x4 Bit-Matrix Multiplier

This block multiplies two square matrices whose elements are single bits read as unsigned integers, producing C = A x B. A grid of multiply-accumulate cells does the work. Each cell keeps one result element. Left operands move east along the rows and right operands move south down the columns. Each hop between cells passes through a register.

A sequencer captures both matrices when a start strobe arrives and clears every accumulator and every inter-cell register. It then feeds the west edge of row i with row i of A, delayed by i cycles. It feeds the north edge of column j with column j of B, delayed by j cycles. Zeros are sent before and after the data. Because of these delays, A[i][r] and B[r][j] reach cell (i,j) in the same cycle. One-bit operands reduce every product to an AND.

The done flag rises once the far corner cell has taken its last operand pair. The results then hold until the next start. The total latency is linear in the matrix order.

Top module: `sysmm_top`

## Requirements
- R1: After reset, done is 0 and every result field is 0.
- R2: A[i][r] is a_mat bit i*4+r, and B[r][j] is b_mat bit r*4+j, with indices counted from 0. Result C[i][j] is the 3-bit field of c_flat starting at bit (i*4+j)*3. It equals the number of r for which both A[i][r] and B[r][j] are 1.
- R3: Every result field stays in the range 0 to 4 at all times.
- R4: In the cycle after start is sampled high, done is 0 and all result fields are 0.
- R5: done rises exactly 10 clock edges after the edge that samples start.
- R6: Once a start has been sampled, later changes on a_mat and b_mat do not affect the results. After done rises, done and all results hold unchanged until the next start.
- R7: A start sampled while a computation is still running abandons that computation. The block then delivers the product of the newly loaded matrices, with the same latency as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe that loads the matrices and begins a product |
| a_mat | input | 16 | Left matrix, bit i*4+r holds A[i][r] |
| b_mat | input | 16 | Right matrix, bit r*4+j holds B[r][j] |
| done | output | 1 | High while the result matrix is complete and valid |
| c_flat | output | 48 | Sixteen 3-bit result fields, C[i][j] at bit (i*4+j)*3 |

## Verification
The all-zero matrix checks that nothing builds up in the cells without operands. The all-ones pair drives every field to its maximum of 4. Identity operands check the bit mapping, because a transposed index or a missing skew delay puts ones in the wrong fields. Single-one matrices swept against an all-ones partner check each A and B position in turn. A long run of pseudo-random pairs checks the rest of the datapath. Further runs scramble the input ports during and after a product, and one run restarts mid-computation, so that operand capture and restart are tested separately.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
   // order of the square matrices
   localparam int unsigned DIM_DEFAULT = 4;

   // accumulator width able to hold the value n
   function automatic int unsigned acc_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction

   // number of feed steps until the far corner cell has consumed its last pair
   function automatic int unsigned feed_steps(input int unsigned n);
      return 3 * n - 2;
   endfunction
endpackage

// File: rtl/sysmm_cell.sv
module sysmm_cell #(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          a_bit,
   input  logic          b_bit,
   output logic [CW-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (clr)
         acc <= '0;
      else if (en)
         acc <= acc + CW'(a_bit & b_bit);
   end
endmodule

// File: rtl/sysmm_link.sv
// Registered chain of operand hops along one row or column.
// tap[0] is the edge input; tap[k] is the value seen by the k-th cell.
module sysmm_link #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         edge_in,
   output logic [N-1:0] tap
);
   logic [N-2:0] hop_q;

   assign tap = {hop_q, edge_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hop_q <= '0;
      else if (clr)
         hop_q <= '0;
      else if (en)
         hop_q <= tap[N-2:0];
   end
endmodule

// File: rtl/sysmm_seq.sv
// Captures operands, steps the feed counter and skews the edge streams.
module sysmm_seq #(
   parameter int unsigned N = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N*N-1:0] a_mat,
   input  logic [N*N-1:0] b_mat,
   output logic           busy,
   output logic           done,
   output logic [N-1:0]   west,
   output logic [N-1:0]   north
);
   localparam int unsigned STEPS = sysmm_pkg::feed_steps(N);
   localparam int unsigned SW    = $clog2(STEPS);
   localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

   logic [N*N-1:0] a_q, b_q;
   logic [SW-1:0]  step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         step_q <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else if (start) begin
         a_q    <= a_mat;
         b_q    <= b_mat;
         step_q <= '0;
         busy   <= 1'b1;
         done   <= 1'b0;
      end else if (busy) begin
         if (step_q == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   // row i carries A[i][t-i]; column j carries B[t-j][j]; zero outside the window
   for (genvar k = 0; k < N; k++) begin : g_edge
      always_comb begin
         int unsigned t;
         int unsigned r;
         t = int'(step_q);
         r = t - k;
         west[k]  = 1'b0;
         north[k] = 1'b0;
         if (busy && t >= k && r < N) begin
            west[k]  = a_q[k*N + r];
            north[k] = b_q[r*N + k];
         end
      end
   end
endmodule

// File: rtl/sysmm_top.sv
module sysmm_top #(
   parameter int unsigned N  = sysmm_pkg::DIM_DEFAULT,
   parameter int unsigned CW = sysmm_pkg::acc_width(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N*N-1:0]    a_mat,
   input  logic [N*N-1:0]    b_mat,
   output logic              done,
   output logic [N*N*CW-1:0] c_flat
);
   if (N < 2 || N > 8) begin : g_bad_dim
      $error("sysmm_top: N must lie in 2..8");
   end
   if (CW < sysmm_pkg::acc_width(N)) begin : g_bad_cw
      $error("sysmm_top: CW too narrow for a full dot product");
   end

   logic         busy;
   logic [N-1:0] west, north;
   logic [N-1:0][N-1:0] a_tap;   // a_tap[i][j]: left operand at cell (i,j)
   logic [N-1:0][N-1:0] b_tap;   // b_tap[j][i]: right operand at cell (i,j)

   sysmm_seq #(.N(N)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .a_mat (a_mat),
      .b_mat (b_mat),
      .busy  (busy),
      .done  (done),
      .west  (west),
      .north (north)
   );

   for (genvar i = 0; i < N; i++) begin : g_row
      sysmm_link #(.N(N)) u_row (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (start),
         .en      (busy),
         .edge_in (west[i]),
         .tap     (a_tap[i])
      );
   end

   for (genvar j = 0; j < N; j++) begin : g_col
      sysmm_link #(.N(N)) u_col (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (start),
         .en      (busy),
         .edge_in (north[j]),
         .tap     (b_tap[j])
      );
   end

   for (genvar i = 0; i < N; i++) begin : g_mi
      for (genvar j = 0; j < N; j++) begin : g_mj
         sysmm_cell #(.CW(CW)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start),
            .en    (busy),
            .a_bit (a_tap[i][j]),
            .b_bit (b_tap[j][i]),
            .acc   (c_flat[(i*N+j)*CW +: CW])
         );
      end
   end
endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
   parameter int unsigned N  = 4,
   parameter int unsigned CW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic [N*N*CW-1:0] c_flat
);
   localparam int unsigned LAT = sysmm_pkg::feed_steps(N);

   // cycles since the last start, counting stops once done is up
   int unsigned since_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_q <= 0;
      else if (start)
         since_q <= 1;
      else if (since_q != 0 && !done)
         since_q <= since_q + 1;
   end

   // R4
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && c_flat == '0));

   // R5
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> since_q == LAT + 1);

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(c_flat)));

   // R6
   done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(start));

   for (genvar k = 0; k < N*N; k++) begin : g_rng
      // R3
      cell_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         int'(c_flat[k*CW +: CW]) <= N);
   end
endmodule

bind sysmm_top sysmm_chk #(.N(N), .CW(CW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .done   (done),
   .c_flat (c_flat)
);

// File: tb/sysmm_top_test.sv
module sysmm_top_test;
   localparam int N  = 4;
   localparam int CW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [N*N-1:0]    a_in = '0;
   logic [N*N-1:0]    b_in = '0;
   logic              done;
   logic [N*N*CW-1:0] c_flat;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;   // 50 MHz

   sysmm_top uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .a_mat  (a_in),
      .b_mat  (b_in),
      .done   (done),
      .c_flat (c_flat)
   );

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   function automatic int expect_c(input logic [15:0] a, input logic [15:0] b,
                                   input int i, input int j);
      int s;
      s = 0;
      for (int r = 0; r < N; r++) s += int'(a[i*N + r] & b[r*N + j]);
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_all(input logic [15:0] a, input logic [15:0] b, input string req);
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            int act;
            int ex;
            act = int'(c_flat[(i*N+j)*CW +: CW]);
            ex  = expect_c(a, b, i, j);
            check(act == ex, req, act, ex);
            check(act <= N, "R3", act, N);
         end
   endtask

   // pulse start, then scramble the ports while the product runs
   task automatic launch(input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      a_in  = a;
      b_in  = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R4 done", int'(done), 0);
      check(c_flat == '0, "R4 clear", int'(c_flat != '0), 0);
      seed = nxt(seed);
      a_in = seed[15:0];   // R6: must be ignored
      b_in = seed[31:16];
   endtask

   task automatic finish(input logic [15:0] a, input logic [15:0] b, input string req);
      int cyc;
      cyc = 0;
      while (!done && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc == 10, "R5 latency", cyc, 10);
      check_all(a, b, req);
   endtask

   task automatic run(input logic [15:0] a, input logic [15:0] b, input string req);
      launch(a, b);
      finish(a, b, req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done == 1'b0, "R1 done", int'(done), 0);
      check(c_flat == '0, "R1 results", int'(c_flat != '0), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R1 done after release", int'(done), 0);

      run(16'h0000, 16'h0000, "R2 zeros");
      run(16'hFFFF, 16'hFFFF, "R2 R3 all ones");
      run(16'h8421, 16'h8421, "R2 identity");
      run(16'h8421, 16'hA5C3, "R2 identity left");
      run(16'h5A3C, 16'h8421, "R2 identity right");
      for (int k = 0; k < N*N; k++) begin
         run(16'(1) << k, 16'hFFFF, "R2 single A bit");
         run(16'hFFFF, 16'(1) << k, "R2 single B bit");
      end
      for (int t = 0; t < 60; t++) begin
         logic [15:0] ra;
         logic [15:0] rb;
         seed = nxt(seed);
         ra = seed[15:0];
         rb = seed[31:16];
         run(ra, rb, "R2 random");
      end

      // R6: results and done hold after completion while inputs move
      begin
         logic [N*N*CW-1:0] snap;
         run(16'h9C63, 16'h36E1, "R6 before hold");
         snap = c_flat;
         for (int h = 0; h < 6; h++) begin
            @(negedge clk);
            seed = nxt(seed);
            a_in = seed[15:0];
            b_in = seed[31:16];
         end
         @(negedge clk);
         check(done == 1'b1, "R6 done held", int'(done), 1);
         check(c_flat == snap, "R6 results held", int'(c_flat != snap), 0);
      end

      // R7: restart in the middle of a product
      launch(16'hFFFF, 16'hFFFF);
      repeat (4) @(negedge clk);
      launch(16'h1248, 16'hF0F0);
      finish(16'h1248, 16'hF0F0, "R7 restart");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule